// File: doc/BRIEF.md
# Channel-Group Packer with Run-Length Compression

This block is the readout stage of a 32-channel logic analyzer. A memory reader presents stored 32-bit samples on a valid/ready stream, already in readout order (newest sample first); the block keeps that order. It drops the bytes of channel groups the configuration has switched off, optionally compresses runs of repeated samples into count words, and serializes every resulting word into a byte stream with its own valid/ready handshake. Each channel group is one byte of the sample, and the bytes of the enabled groups are packed together so that a transmitted word is one to four bytes long, lowest enabled group first.

Configuration comes from a flag register and a sample limit, both held steady during a readout. Bit 0 selects demux mode, bits 2 to 5 switch off groups 0 to 3, and bit 8 selects run-length compression. Bits 1, 6, 9, 10 and 11 belong to the capture side (noise filter, clock source, channel swap, the two test patterns) and are ignored here. A synchronous reset starts a new readout, which clears the limit accounting and any pending run.

In demux mode every incoming word carries two samples, captured on the two halves of the channel set. The block unfolds it into two samples: the upper half, groups 2 and 3, moved into the positions of groups 0 and 1 and sent first, then the lower half. Only groups 0 and 1 are ever transmitted in this mode.

Top module: `chan_pack`

## Requirements
- R1: After reset `m_valid` is low and `s_ready` is high.
- R2: A flag bit 2+g set to 1 removes byte g (bits 8g+7..8g) of every sample from the output; the remaining bytes leave lowest group first, so a word of n enabled groups is n bytes.
- R3: With all groups enabled and both demux and compression off, each sample leaves as four bytes, bits 7..0 first and bits 31..24 last, and samples leave in their input order.
- R4: With flag bit 0 set, each input word yields two samples, first bits 31..16 and then bits 15..0, each sent as its group-0 byte then its group-1 byte; group 0/1 disable bits (2, 3) apply to both, and bits 4 and 5 have no effect.
- R5: With flag bit 8 set, bit 8n-1 of a data word of n bytes (the top bit of its last byte) is forced to 0; a sample equal to the previous one in its transmitted bytes produces no data word, and the run is reported by a count word with bit 8n-1 set whose lower bits hold the number of extra repeats, sent before the next differing sample.
- R6: When the repeat count of a run reaches 2^(8n-1)-1, that count word is sent at once and counting restarts at zero for the same sample.
- R7: The number of samples the output stands for (one per data word, the value of each count word) never exceeds `cfg_limit`; once the limit is reached, further input is accepted and discarded, and a run still pending at the limit is sent as a count word at once. A limit of 0 yields no output.
- R8: Flag bits 1, 6, 9, 10 and 11 have no effect on the output.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value.
- R10: With every group switched off, no bytes are sent and input is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; starts a readout |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Sample accepted this cycle when high with `s_valid` |
| s_data | input | GROUPS*GROUP_W | Stored sample |
| cfg_flags | input | FLAG_W | Flag register (demux, group disables, compression) |
| cfg_limit | input | LIMIT_W | Maximum number of samples represented |
| m_valid | output | 1 | Output byte available |
| m_ready | input | 1 | Output byte taken when high with `m_valid` |
| m_data | output | GROUP_W | Output byte |

## Verification
With the path idle, the first byte of a sample's word is offered on `m_data` two clocks after the input handshake: one register in the unfold stage, one in the compression stage, then the serializer. Each further byte follows one clock after the previous one is taken, and a count word adds one clock before the differing sample that ends its run. The bench does not tie its checks to those cycle numbers. It pushes the expected bytes into a queue when it drives a sample, and the monitor compares each byte at the falling edge before the rising edge that completes the transfer. A stalled byte is compared again one cycle later to check that it has held. At the end of each test the bench allows a drain window, and it reports any extra byte as a failure.

// File: rtl/chan_pack_pkg.sv
// Shared definitions for the channel-group packer: flag register bit
// positions that the readout stage decodes.
package chan_pack_pkg;
    localparam int FLG_DEMUX  = 0;   // two half-width samples per word
    localparam int FLG_DIS_LO = 2;   // first group-disable bit (group 0)
    localparam int FLG_RLE    = 8;   // run-length compression enable
endpackage

// File: rtl/cp_unfold.sv
// Unfold stage. Holds one input word. Outside demux mode it passes the word
// on unchanged. In demux mode it emits two samples from it: the upper half
// moved into the lower half's positions first, then the lower half.
// Assumes the demux setting is steady while a word is held.
module cp_unfold #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          demux,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [SW-1:0] out_data
);
    localparam int HW = SW / 2;

    logic          full;
    logic          phase;      // 0: upper half pending, 1: lower half pending
    logic [SW-1:0] hold;
    logic          last_phase;

    // Decide whether the held word finishes with the current output.
    always_comb begin
        last_phase = !demux || phase;
        in_ready   = !full || (out_ready && last_phase);
        out_valid  = full;
        if (!demux)
            out_data = hold;
        else if (!phase)
            out_data = {{HW{1'b0}}, hold[SW-1:HW]};
        else
            out_data = {{HW{1'b0}}, hold[HW-1:0]};
    end

    // Load a new word or step through its halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            phase <= 1'b0;
            hold  <= '0;
        end else if (in_valid && in_ready) begin
            full  <= 1'b1;
            phase <= 1'b0;
            hold  <= in_data;
        end else if (full && out_ready) begin
            if (last_phase)
                full <= 1'b0;
            else
                phase <= 1'b1;
        end
    end
endmodule

// File: rtl/cp_compact.sv
// Group compactor (combinational). Keeps the bytes of enabled groups and
// packs them into the low end of the word, lowest group first. In demux
// mode only the lower half of the groups can be enabled.
module cp_compact #(
    parameter int GROUPS = 4,
    parameter int GW     = 8,
    parameter int NW     = $clog2(GROUPS + 1)
) (
    input  logic [GROUPS*GW-1:0] smp,
    input  logic [GROUPS-1:0]    dis,
    input  logic                 demux,
    output logic [GROUPS*GW-1:0] pk,
    output logic [NW-1:0]        nbytes
);
    logic [GROUPS-1:0] en;

    // One enable per group: not disabled, and inside the demux half if folding.
    for (genvar g = 0; g < GROUPS; g++) begin : g_en
        if (g < GROUPS / 2) begin : g_low
            assign en[g] = !dis[g];
        end else begin : g_high
            assign en[g] = !dis[g] && !demux;
        end
    end

    // Pack the enabled bytes downward and count them.
    always_comb begin
        int k;
        k  = 0;
        pk = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (en[g]) begin
                pk[k*GW +: GW] = smp[g*GW +: GW];
                k = k + 1;
            end
        end
        nbytes = NW'(k);
    end
endmodule

// File: rtl/cp_rle.sv
// Compression and limit stage. Takes packed samples, counts repeats when
// compression is on, and emits data words and count words into a one-word
// output register. It stops output once the sample limit is covered and
// discards further input. Assumes flags and limit are steady during a readout.
module cp_rle #(
    parameter int SW      = 32,
    parameter int GW      = 8,
    parameter int NW      = 3,
    parameter int LIMIT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rle_en,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SW-1:0]      in_word,
    input  logic [NW-1:0]      in_n,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SW-1:0]      out_word,
    output logic [NW-1:0]      out_n,
    output logic               out_cnt
);
    localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

    logic [LIMIT_W-1:0] acct;        // samples already accounted for
    logic               have_prev;
    logic [SW-1:0]      prev;
    logic [SW-1:0]      run;         // extra repeats not yet reported
    logic [SW-1:0]      top_m;       // flag bit of the current word size
    logic [SW-1:0]      max_run;
    logic [SW-1:0]      data_m;
    logic [SW-1:0]      run_nx;
    logic               done, last, can_load, match, flush_first;
    logic               take, emit, emit_cnt;
    logic [SW-1:0]      emit_word;

    // Derive the word-size dependent flag position and run ceiling.
    always_comb begin
        if (in_n == '0) begin
            top_m   = '0;
            max_run = ONE;
        end else begin
            top_m   = ONE << (GW * int'(in_n) - 1);
            max_run = top_m - ONE;
        end
        data_m = rle_en ? (in_word & ~top_m) : in_word;
    end

    // Choose what this cycle consumes and emits.
    always_comb begin
        done        = acct >= limit;
        last        = (acct + 1'b1) == limit;
        can_load    = !out_valid || out_ready;
        match       = rle_en && have_prev && (data_m == prev);
        flush_first = rle_en && !match && (run != '0);
        run_nx      = run + ONE;
        in_ready    = done || (can_load && !flush_first);
        take        = in_valid && in_ready && !done;
        emit        = 1'b0;
        emit_cnt    = 1'b0;
        emit_word   = data_m;
        if (in_valid && !done && can_load) begin
            if (flush_first) begin
                emit      = 1'b1;
                emit_cnt  = 1'b1;
                emit_word = run | top_m;
            end else if (match) begin
                if (run_nx == max_run || last) begin
                    emit      = 1'b1;
                    emit_cnt  = 1'b1;
                    emit_word = run_nx | top_m;
                end
            end else begin
                emit = 1'b1;
            end
        end
    end

    // Update run state and the limit account.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acct      <= '0;
            have_prev <= 1'b0;
            prev      <= '0;
            run       <= '0;
        end else if (in_valid && !done && can_load) begin
            if (flush_first) begin
                run <= '0;
            end else if (match) begin
                acct <= acct + 1'b1;
                run  <= emit_cnt ? '0 : run_nx;
            end else begin
                acct      <= acct + 1'b1;
                prev      <= data_m;
                have_prev <= 1'b1;
            end
        end
    end

    // Output word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_n     <= '0;
            out_cnt   <= 1'b0;
        end else if (can_load) begin
            out_valid <= emit;
            if (emit) begin
                out_word <= emit_word;
                out_n    <= in_n;
                out_cnt  <= emit_cnt;
            end
        end
    end

    logic unused_take;
    assign unused_take = take;
endmodule

// File: rtl/cp_serial.sv
// Byte serializer. Takes a packed word with its byte count and sends the
// bytes lowest first. A word of zero bytes is taken and dropped.
module cp_serial #(
    parameter int SW = 32,
    parameter int GW = 8,
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_word,
    input  logic [NW-1:0] in_n,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [GW-1:0] out_data
);
    logic          busy;
    logic [SW-1:0] w;
    logic [NW-1:0] n_r;
    logic [NW-1:0] idx;
    logic          at_end;

    // Handshake and byte select.
    always_comb begin
        at_end    = (idx + 1'b1) == n_r;
        in_ready  = !busy || (out_ready && at_end);
        out_valid = busy;
        out_data  = w[int'(idx)*GW +: GW];
    end

    // Load a word, then step through its bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            w    <= '0;
            n_r  <= '0;
            idx  <= '0;
        end else if (in_valid && in_ready) begin
            busy <= (in_n != '0);
            w    <= in_word;
            n_r  <= in_n;
            idx  <= '0;
        end else if (busy && out_ready) begin
            if (at_end)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/chan_pack.sv
// Channel-group packer top: unfold -> compact -> compress/limit -> serialize.
// A synchronous reset starts a readout. Flags and limit are assumed steady
// while a readout runs.
module chan_pack
    import chan_pack_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter int GROUP_W = 8,
    parameter int FLAG_W  = 12,
    parameter int LIMIT_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_valid,
    output logic                      s_ready,
    input  logic [GROUPS*GROUP_W-1:0] s_data,
    input  logic [FLAG_W-1:0]         cfg_flags,
    input  logic [LIMIT_W-1:0]        cfg_limit,
    output logic                      m_valid,
    input  logic                      m_ready,
    output logic [GROUP_W-1:0]        m_data
);
    localparam int SW = GROUPS * GROUP_W;
    localparam int NW = $clog2(GROUPS + 1);

    logic          demux, rle_en;
    logic [GROUPS-1:0] dis;
    logic          u_valid, u_ready;
    logic [SW-1:0] u_data;
    logic [SW-1:0] c_word;
    logic [NW-1:0] c_n;
    logic          rle_valid, rle_ready, rle_cnt;
    logic [SW-1:0] rle_word;
    logic [NW-1:0] rle_n;

    // Decode the flag fields this stage uses.
    always_comb begin
        demux  = cfg_flags[FLG_DEMUX];
        rle_en = cfg_flags[FLG_RLE];
        dis    = cfg_flags[FLG_DIS_LO +: GROUPS];
    end

    cp_unfold #(.SW(SW)) u_unfold (
        .clk(clk), .rst_n(rst_n), .demux(demux),
        .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
        .out_valid(u_valid), .out_ready(u_ready), .out_data(u_data)
    );

    cp_compact #(.GROUPS(GROUPS), .GW(GROUP_W), .NW(NW)) u_compact (
        .smp(u_data), .dis(dis), .demux(demux), .pk(c_word), .nbytes(c_n)
    );

    cp_rle #(.SW(SW), .GW(GROUP_W), .NW(NW), .LIMIT_W(LIMIT_W)) u_rle (
        .clk(clk), .rst_n(rst_n), .rle_en(rle_en), .limit(cfg_limit),
        .in_valid(u_valid), .in_ready(u_ready), .in_word(c_word), .in_n(c_n),
        .out_valid(rle_valid), .out_ready(rle_ready), .out_word(rle_word),
        .out_n(rle_n), .out_cnt(rle_cnt)
    );

    cp_serial #(.SW(SW), .GW(GROUP_W), .NW(NW)) u_serial (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rle_valid), .in_ready(rle_ready), .in_word(rle_word), .in_n(rle_n),
        .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data)
    );
endmodule

// File: rtl/chan_pack_chk.sv
// Checker for chan_pack: output hold, reset state, compressed word format
// and limit accounting, watched at the stage boundaries.
module chan_pack_chk #(
    parameter int SW      = 32,
    parameter int GW      = 8,
    parameter int NW      = 3,
    parameter int LIMIT_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rle_en,
    input logic [LIMIT_W-1:0] cfg_limit,
    input logic               r_valid,
    input logic               r_ready,
    input logic [SW-1:0]      r_word,
    input logic [NW-1:0]      r_n,
    input logic               r_cnt,
    input logic               m_valid,
    input logic               m_ready,
    input logic [GW-1:0]      m_data
);
    localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

    logic [SW-1:0] top;
    logic [47:0]   total;   // samples represented by words handed on

    // Flag position for the word on the compression stage output.
    always_comb top = (r_n == '0) ? '0 : (ONE << (GW * int'(r_n) - 1));

    // Accumulate what the handed-on words stand for.
    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else if (r_valid && r_ready)
            total <= total + (r_cnt ? 48'(r_word & ~top) : 48'd1);
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    p_data_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && rle_en && !r_cnt) |-> ((r_word & top) == '0));

    p_count_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_cnt) |-> ((r_word & top) != '0 && (r_word & ~top) != '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        total <= 48'(cfg_limit));
endmodule

bind chan_pack chan_pack_chk #(
    .SW(GROUPS * GROUP_W), .GW(GROUP_W), .NW($clog2(GROUPS + 1)), .LIMIT_W(LIMIT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rle_en(rle_en), .cfg_limit(cfg_limit),
    .r_valid(rle_valid), .r_ready(rle_ready), .r_word(rle_word), .r_n(rle_n),
    .r_cnt(rle_cnt), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/sim_chan_pack.sv
`timescale 1ns/1ps
module sim_chan_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic [11:0] cfg_flags = '0;
    logic [23:0] cfg_limit = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [7:0]  m_data;

    chan_pack u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .cfg_flags(cfg_flags), .cfg_limit(cfg_limit),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    always #10 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    string       cur_req = "R1";
    logic [7:0]  exp_q[$];
    bit          stall_mode = 0;
    bit          prev_stall = 0;
    logic [7:0]  prev_d = '0;

    // reference model state
    int unsigned m_acct;
    bit          m_have;
    logic [31:0] m_prev;
    longint unsigned m_run;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Output ready pattern, changed after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        m_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Monitor: compare transfers and stall holding away from the edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_stall = 0;
        end else begin
            if (prev_stall)
                check(m_valid && m_data == prev_d, "R9", {m_valid, m_data}, {1'b1, prev_d});
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0)
                    check(0, cur_req, m_data, 0);
                else
                    check(m_data == exp_q[0], cur_req, m_data, exp_q[0]);
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            prev_stall = m_valid && !m_ready;
            prev_d = m_data;
        end
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic push_word(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(w[i*8 +: 8]);
    endtask

    // Expected behaviour for one unfolded sample, written from R2, R5-R7.
    task automatic model_sub(input logic [31:0] x, input logic [3:0] en);
        logic [31:0] p;
        logic [31:0] topb;
        longint unsigned maxr;
        bit rle;
        int n;
        p = '0;
        n = 0;
        rle = cfg_flags[8];
        for (int g = 0; g < 4; g++)
            if (en[g]) begin p[n*8 +: 8] = x[g*8 +: 8]; n++; end
        if (m_acct >= cfg_limit) return;
        topb = (n == 0) ? 32'd0 : (32'd1 << (n*8 - 1));
        maxr = (n == 0) ? 1 : longint'(topb) - 1;
        if (rle) p = p & ~topb;
        if (rle && m_have && p == m_prev) begin
            m_run++;
            m_acct++;
            if (m_run == maxr || m_acct == cfg_limit) begin
                push_word(32'(m_run) | topb, n);
                m_run = 0;
            end
        end else begin
            if (rle && m_run != 0) begin
                push_word(32'(m_run) | topb, n);
                m_run = 0;
            end
            push_word(p, n);
            m_prev = p;
            m_have = 1;
            m_acct++;
        end
    endtask

    task automatic model_sample(input logic [31:0] s);
        logic [3:0] en;
        for (int g = 0; g < 4; g++)
            en[g] = !cfg_flags[2+g] && (!cfg_flags[0] || g < 2);
        if (cfg_flags[0]) begin
            model_sub({16'h0, s[31:16]}, en);
            model_sub({16'h0, s[15:0]}, en);
        end else begin
            model_sub(s, en);
        end
    endtask

    // Driver: record expectation, then hand the sample over.
    task automatic send(input logic [31:0] s);
        bit ok;
        model_sample(s);
        s_data = s;
        s_valid = 1'b1;
        do begin
            ok = s_ready;
            @(negedge clk);
        end while (!ok);
        s_valid = 1'b0;
    endtask

    task automatic start_test(input logic [11:0] f, input logic [23:0] lim, input string req, input bit stall);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_flags = f;
        cfg_limit = lim;
        stall_mode = stall;
        cur_req = req;
        m_acct = 0; m_have = 0; m_prev = '0; m_run = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic end_test();
        int waited;
        waited = 0;
        while (exp_q.size() != 0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!m_valid, "R1", m_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_valid && s_ready, "R1", {m_valid, s_ready}, 2'b01);

        // R3: all groups, plain, with output stalls (R9 checked by monitor)
        start_test(12'h000, 24'd100, "R3", 1);
        send(32'h11223344); send(32'hA5B6C7D8); send(32'h00FF00FF);
        end_test();

        // R2: groups 1 and 3 off
        start_test(12'h028, 24'd100, "R2", 0);
        send(32'h11223344); send(32'hDEADBEEF);
        end_test();

        // R2: only group 3 on
        start_test(12'h01C, 24'd100, "R2", 1);
        send(32'h81000000); send(32'h7F123456);
        end_test();

        // R4: demux, all low groups on
        start_test(12'h001, 24'd100, "R4", 0);
        send(32'hAABBCCDD); send(32'h01020304);
        end_test();

        // R4: demux, group 1 off, bits 4 and 5 set without effect
        start_test(12'h039, 24'd100, "R4", 1);
        send(32'hAABBCCDD); send(32'h55667788);
        end_test();

        // R5: compression, run then change, top bit masking
        start_test(12'h100, 24'd100, "R5", 0);
        send(32'h11223344); send(32'h11223344); send(32'h11223344);
        send(32'h9A000001); send(32'h12345678);
        end_test();

        // R5: a difference only in a disabled group keeps the run
        start_test(12'h120, 24'd100, "R5", 1);
        send(32'h00ABCDEF); send(32'h77ABCDEF); send(32'hFFABCDEF); send(32'h00000001);
        end_test();

        // R6: saturation with one byte words (ceiling 127)
        start_test(12'h138, 24'd200, "R6", 0);
        for (int i = 0; i < 130; i++) send(32'h00000055);
        send(32'h00000021);
        end_test();

        // R7: limit without compression, extra input discarded
        start_test(12'h000, 24'd2, "R7", 0);
        send(32'h01010101); send(32'h02020202); send(32'h03030303); send(32'h04040404);
        end_test();

        // R7: run pending at the limit is flushed
        start_test(12'h130, 24'd5, "R7", 1);
        for (int i = 0; i < 8; i++) send(32'h00004242);
        send(32'h00001111);
        end_test();

        // R7: limit of zero
        start_test(12'h000, 24'd0, "R7", 0);
        send(32'hCAFEF00D); send(32'h12345678);
        end_test();

        // R8: capture-side bits ignored
        start_test(12'hE42, 24'd100, "R8", 0);
        send(32'h13579BDF); send(32'h2468ACE0);
        end_test();

        // R10: every group off, input still accepted
        start_test(12'h03C, 24'd100, "R10", 0);
        send(32'h11111111); send(32'h22222222); send(32'h33333333);
        check(s_ready, "R10", s_ready, 1);
        end_test();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule